// File: doc/BRIEF.md
# Serial Flash Byte Access Engine

This block moves one byte at a time between a register interface and a serial NOR flash. Software loads a flash address once. It picks the read flavour through a lane-mode register and a read-configuration register, then starts each access by writing a command code. A read command runs one flash read frame and leaves the returned byte in a read-data register. A write command sends a write-enable frame, then a page-program frame that carries the byte held in the write-data register. After every access the internal address steps forward by one, so a run of commands covers a run of bytes.

The flash side is a four-lane serial bus in clock mode 0. The opcode always goes out on one lane. The address and data phases use one, two or four lanes, depending on the mode. Fast, dual and quad reads put eight dummy clocks after the address. While the engine is busy, software polls the command register until it reads zero.

Top module: `flash_byte_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low and no lane is driven. The command register reads 0x00, the lane register reads 0x00, the read configuration reads 0x00, and the two read-opcode registers read 0x0B (offset 0x2c) and 0x6B (offset 0x30).
- R2: Writing 0x81 to offset 0x00 starts one byte read. Offset 0x00 reads back 0x81 while the read runs and 0x00 once it ends. The received byte can then be read at offset 0x0c.
- R3: Writing 0x90 to offset 0x00 starts one byte write. The engine sends a single-lane 8-clock frame with opcode 0x06 and raises chip select. It then sends a single-lane frame of opcode 0x02, the address and the byte last written to offset 0x1c, which is 40 clocks in all. Offset 0x00 reads 0x90 until this ends. Lane settings have no effect on writes.
- R4: The 32-bit address is written and read as four bytes, least significant first, at offsets 0x40 to 0x43. Its low 24 bits go out MSB first. After every completed access it increases by one, with carry between the bytes.
- R5: The lane register at offset 0xcc is decoded as follows. Bit 2 selects quad read and takes priority over bit 0, which selects dual read. Bit 3 widens the address to four lanes, but only for quad read. Bit 1 widens the address to two lanes, but only for dual read. The value 0 gives single-lane reads.
- R6: Quad reads use the opcode at offset 0x30. Dual reads, and fast single-lane reads, use the opcode at offset 0x2c. A single-lane read with fast mode off uses opcode 0x03.
- R7: Writing 0x01 to the read configuration at offset 0x64 selects fast single-lane reads. Fast mode is bit 0 of that register.
- R8: Fast, dual and quad reads put exactly 8 dummy clocks between the address and the data. No lane is driven during the dummy clocks or the data phase of a read.
- R9: On one lane the engine drives lane 0 and reads lane 1. On two lanes, lane 1 carries the higher bit of each pair. On four lanes, lane 3 carries the most significant bit of each nibble.
- R10: A write to any register while a command runs is ignored. A command code other than 0x81 or 0x90 is ignored: offset 0x00 stays 0x00 and no frame starts.
- R11: The serial clock idles low, and each high phase lasts HalfDiv system clocks. Outputs change while the clock is low. Inputs are sampled at the end of each high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational on regAddr) |
| sclk | output | 1 | Serial flash clock |
| csN | output | 1 | Flash chip select, active low |
| ioOut | output | 4 | Lane output values |
| ioOe | output | 4 | Lane output enables |
| ioIn | input | 4 | Lane input values |

## Verification
A wrong phase state or a wrong clock count shows up at once as a frame of the wrong length at chip select rise. A wrong lane decode puts a wrong opcode or address into the flash model within the same frame. A shift or sampling fault returns a wrong byte at offset 0x0c as soon as the command register reads zero. A broken address counter shows up only on the next access, or when the address bytes are read back, which the bench does after a carry. A bus-release fault shows up during the dummy or data clocks as a driven lane.

// File: rtl/fbe_pkg.sv
package fbe_pkg;

  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } lane_e;

  typedef enum logic [2:0] {
    FLD_WREN,
    FLD_PROG,
    FLD_RD_STD,
    FLD_RD_FAST,
    FLD_RD_QUAD,
    FLD_ADDR,
    FLD_WDATA
  } fld_e;

  typedef struct packed {
    logic  load;
    fld_e  fld;
    lane_e lane;
    logic  drive;
    logic  capture;
    logic  clkRun;
    logic  select;
    logic  finish;
  } strobe_t;

  localparam logic [7:0] CMD_BYTE_RD = 8'h81;
  localparam logic [7:0] CMD_BYTE_WR = 8'h90;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;

  localparam logic [7:0] OFF_CMD    = 8'h00;
  localparam logic [7:0] OFF_RDDATA = 8'h0c;
  localparam logic [7:0] OFF_WRDATA = 8'h1c;
  localparam logic [7:0] OFF_OPFAST = 8'h2c;
  localparam logic [7:0] OFF_OPQUAD = 8'h30;
  localparam logic [7:0] OFF_ADDR0  = 8'h40;
  localparam logic [7:0] OFF_RDCFG  = 8'h64;
  localparam logic [7:0] OFF_LANE   = 8'hcc;

endpackage

// File: rtl/fbe_regs.sv
module fbe_regs
  import fbe_pkg::*;
#(
  parameter int AddrBytes = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [7:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic        finish,
  input  logic [7:0]  rxByte,
  output logic        goRd,
  output logic        goWr,
  output logic        isRead,
  output logic [3:0]  laneCfg,
  output logic        fastEn,
  output logic [7:0]  opcFast,
  output logic [7:0]  opcQuad,
  output logic [7:0]  wrByte,
  output logic [31:0] addrQ
);

  logic [7:0] cmdQ, rdDataQ, wrByteQ, opcFastQ, opcQuadQ, rdCfgQ;
  logic [3:0] laneQ;
  logic       busy, wrOpen;

  assign busy   = (cmdQ != 8'h00);
  assign wrOpen = regWr && !busy;
  assign goRd   = wrOpen && regAddr == OFF_CMD && regWdata == CMD_BYTE_RD;
  assign goWr   = wrOpen && regAddr == OFF_CMD && regWdata == CMD_BYTE_WR;
  assign isRead = (cmdQ == CMD_BYTE_RD);

  assign laneCfg = laneQ;
  assign fastEn  = rdCfgQ[0];
  assign opcFast = opcFastQ;
  assign opcQuad = opcQuadQ;
  assign wrByte  = wrByteQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ     <= 8'h00;
      rdDataQ  <= 8'h00;
      wrByteQ  <= 8'h00;
      opcFastQ <= 8'h0B;
      opcQuadQ <= 8'h6B;
      rdCfgQ   <= 8'h00;
      laneQ    <= 4'h0;
      addrQ    <= 32'h0;
    end else if (finish) begin
      cmdQ  <= 8'h00;
      addrQ <= addrQ + 32'd1;
      if (isRead) rdDataQ <= rxByte;
    end else if (wrOpen) begin
      if (goRd || goWr) cmdQ <= regWdata;
      if (regAddr == OFF_WRDATA) wrByteQ  <= regWdata;
      if (regAddr == OFF_OPFAST) opcFastQ <= regWdata;
      if (regAddr == OFF_OPQUAD) opcQuadQ <= regWdata;
      if (regAddr == OFF_RDCFG)  rdCfgQ   <= regWdata;
      if (regAddr == OFF_LANE)   laneQ    <= regWdata[3:0];
      for (int i = 0; i < 4; i++) begin
        if (regAddr == OFF_ADDR0 + 8'(i)) addrQ[8*i +: 8] <= regWdata;
      end
    end
  end

  always_comb begin
    regRdata = 8'h00;
    case (regAddr)
      OFF_CMD:    regRdata = cmdQ;
      OFF_RDDATA: regRdata = rdDataQ;
      OFF_WRDATA: regRdata = wrByteQ;
      OFF_OPFAST: regRdata = opcFastQ;
      OFF_OPQUAD: regRdata = opcQuadQ;
      OFF_RDCFG:  regRdata = rdCfgQ;
      OFF_LANE:   regRdata = {4'h0, laneQ};
      default: begin
        for (int i = 0; i < 4; i++) begin
          if (regAddr == OFF_ADDR0 + 8'(i)) regRdata = addrQ[8*i +: 8];
        end
      end
    endcase
  end

  // R2
  cmd_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> cmdQ == 8'h00);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> addrQ == $past(addrQ) + 32'd1);

  // R10
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && busy && !finish) |=> $stable(laneQ) && $stable(wrByteQ) && $stable(rdCfgQ));

endmodule

// File: rtl/fbe_ctrl.sv
module fbe_ctrl
  import fbe_pkg::*;
#(
  parameter int AddrBytes = 3,
  parameter int HalfDiv   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       goRd,
  input  logic       goWr,
  input  logic       isRead,
  input  logic [3:0] laneCfg,
  input  logic       fastEn,
  input  logic       fallStb,
  output strobe_t    strb
);

  localparam int AddrBits  = AddrBytes * 8;
  localparam int CntW      = $clog2(AddrBits + 1);
  localparam int GapCycles = 2 * HalfDiv;
  localparam int GapW      = $clog2(GapCycles + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_GAP, S_OPC, S_ADR, S_DUM, S_DAT, S_WDT, S_DONE
  } st_e;

  st_e             state, nextState;
  logic [CntW-1:0] clkCnt, need;
  logic [GapW-1:0] gapCnt;
  logic            quadRd, dualRd, dummyOn, phaseEnd, loadNow;
  lane_e           dataLane, addrLane, phaseLane;
  fld_e            rdFld, fldNow;

  // mode decode
  assign quadRd  = laneCfg[2];
  assign dualRd  = laneCfg[0] && !laneCfg[2];
  assign dummyOn = quadRd || dualRd || fastEn;

  always_comb begin
    dataLane = quadRd ? LANE_X4 : (dualRd ? LANE_X2 : LANE_X1);
    if (quadRd && laneCfg[3])      addrLane = LANE_X4;
    else if (dualRd && laneCfg[1]) addrLane = LANE_X2;
    else                           addrLane = LANE_X1;
    if (quadRd)                    rdFld = FLD_RD_QUAD;
    else if (dualRd || fastEn)     rdFld = FLD_RD_FAST;
    else                           rdFld = FLD_RD_STD;
  end

  always_comb begin
    case (state)
      S_ADR:        phaseLane = isRead ? addrLane : LANE_X1;
      S_DUM, S_DAT: phaseLane = dataLane;
      default:      phaseLane = LANE_X1;
    endcase
    case (state)
      S_ADR:   need = CntW'(AddrBits) >> phaseLane;
      S_DAT:   need = CntW'(8) >> phaseLane;
      default: need = CntW'(8);
    endcase
  end

  assign phaseEnd = fallStb && (clkCnt == need - CntW'(1));

  always_comb begin
    nextState = state;
    loadNow   = 1'b0;
    fldNow    = FLD_ADDR;
    case (state)
      S_IDLE: begin
        if (goWr) begin
          nextState = S_WREN; loadNow = 1'b1; fldNow = FLD_WREN;
        end else if (goRd) begin
          nextState = S_OPC;  loadNow = 1'b1; fldNow = rdFld;
        end
      end
      S_WREN: if (phaseEnd) nextState = S_GAP;
      S_GAP: begin
        if (gapCnt == GapW'(GapCycles - 1)) begin
          nextState = S_OPC; loadNow = 1'b1; fldNow = FLD_PROG;
        end
      end
      S_OPC: begin
        if (phaseEnd) begin
          nextState = S_ADR; loadNow = 1'b1; fldNow = FLD_ADDR;
        end
      end
      S_ADR: begin
        if (phaseEnd) begin
          if (!isRead) begin
            nextState = S_WDT; loadNow = 1'b1; fldNow = FLD_WDATA;
          end else begin
            nextState = dummyOn ? S_DUM : S_DAT;
          end
        end
      end
      S_DUM:   if (phaseEnd) nextState = S_DAT;
      S_DAT:   if (phaseEnd) nextState = S_DONE;
      S_WDT:   if (phaseEnd) nextState = S_DONE;
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      clkCnt <= '0;
      gapCnt <= '0;
    end else begin
      state <= nextState;
      if (nextState != state) clkCnt <= '0;
      else if (fallStb)       clkCnt <= clkCnt + CntW'(1);
      if (state == S_GAP && nextState == S_GAP) gapCnt <= gapCnt + GapW'(1);
      else                                      gapCnt <= '0;
    end
  end

  always_comb begin
    strb         = '0;
    strb.load    = loadNow;
    strb.fld     = fldNow;
    strb.lane    = phaseLane;
    strb.drive   = (state == S_WREN) || (state == S_OPC) || (state == S_ADR) || (state == S_WDT);
    strb.capture = (state == S_DAT);
    strb.select  = strb.drive || (state == S_DUM) || (state == S_DAT);
    strb.clkRun  = strb.select;
    strb.finish  = (state == S_DONE);
  end

  // R10
  start_only_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goRd || goWr) |-> state == S_IDLE);

  // R3
  gap_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WREN && phaseEnd) |=> !strb.select);

endmodule

// File: rtl/fbe_dp.sv
module fbe_dp
  import fbe_pkg::*;
#(
  parameter int AddrBytes = 3,
  parameter int HalfDiv   = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strb,
  input  logic [7:0]  opcFast,
  input  logic [7:0]  opcQuad,
  input  logic [7:0]  wrByte,
  input  logic [31:0] addrQ,
  input  logic [3:0]  ioIn,
  output logic        sclk,
  output logic        csN,
  output logic [3:0]  ioOut,
  output logic [3:0]  ioOe,
  output logic [7:0]  rxByte,
  output logic        fallStb
);

  localparam int AddrBits = AddrBytes * 8;
  localparam int AddrPad  = 32 - AddrBits;
  localparam int DivW     = (HalfDiv > 1) ? $clog2(HalfDiv) : 1;

  logic [DivW-1:0] divCnt;
  logic            sclkQ, divWrap;
  logic [31:0]     shReg;
  logic [7:0]      rxQ;

  assign divWrap = (divCnt == DivW'(HalfDiv - 1));
  assign fallStb = strb.clkRun && divWrap && sclkQ;
  assign sclk    = sclkQ;
  assign csN     = !strb.select;
  assign rxByte  = rxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      sclkQ  <= 1'b0;
    end else if (!strb.clkRun) begin
      divCnt <= '0;
      sclkQ  <= 1'b0;
    end else if (divWrap) begin
      divCnt <= '0;
      sclkQ  <= !sclkQ;
    end else begin
      divCnt <= divCnt + DivW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strb.load) begin
      case (strb.fld)
        FLD_WREN:    shReg <= {OP_WREN, 24'h0};
        FLD_PROG:    shReg <= {OP_PROG, 24'h0};
        FLD_RD_STD:  shReg <= {OP_READ, 24'h0};
        FLD_RD_FAST: shReg <= {opcFast, 24'h0};
        FLD_RD_QUAD: shReg <= {opcQuad, 24'h0};
        FLD_WDATA:   shReg <= {wrByte, 24'h0};
        default:     shReg <= addrQ << AddrPad;
      endcase
    end else if (fallStb && strb.drive) begin
      case (strb.lane)
        LANE_X2: shReg <= shReg << 2;
        LANE_X4: shReg <= shReg << 4;
        default: shReg <= shReg << 1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxQ <= '0;
    end else if (fallStb && strb.capture) begin
      case (strb.lane)
        LANE_X2: rxQ <= {rxQ[5:0], ioIn[1], ioIn[0]};
        LANE_X4: rxQ <= {rxQ[3:0], ioIn[3:0]};
        default: rxQ <= {rxQ[6:0], ioIn[1]};
      endcase
    end
  end

  always_comb begin
    case (strb.lane)
      LANE_X2: begin ioOut = {2'b00, shReg[31:30]}; ioOe = 4'b0011; end
      LANE_X4: begin ioOut = shReg[31:28];          ioOe = 4'b1111; end
      default: begin ioOut = {3'b000, shReg[31]};   ioOe = 4'b0001; end
    endcase
    if (!strb.drive) ioOe = 4'b0000;
  end

  // R8
  released_on_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> ioOe == 4'b0000);

  // R11
  clock_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !sclkQ);

  // R11
  high_phase_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkQ) |-> strb.clkRun);

endmodule

// File: rtl/flash_byte_engine.sv
module flash_byte_engine
  import fbe_pkg::*;
#(
  parameter int AddrBytes = 3,
  parameter int HalfDiv   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       sclk,
  output logic       csN,
  output logic [3:0] ioOut,
  output logic [3:0] ioOe,
  input  logic [3:0] ioIn
);

  strobe_t     strb;
  logic        goRd, goWr, isRead, fastEn, fallStb;
  logic [3:0]  laneCfg;
  logic [7:0]  opcFast, opcQuad, wrByte, rxByte;
  logic [31:0] addrQ;

  fbe_regs #(.AddrBytes(AddrBytes)) u_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .finish(strb.finish),
    .rxByte(rxByte), .goRd(goRd), .goWr(goWr), .isRead(isRead),
    .laneCfg(laneCfg), .fastEn(fastEn), .opcFast(opcFast),
    .opcQuad(opcQuad), .wrByte(wrByte), .addrQ(addrQ)
  );

  fbe_ctrl #(.AddrBytes(AddrBytes), .HalfDiv(HalfDiv)) u_ctrl (
    .clk(clk), .rstN(rstN), .goRd(goRd), .goWr(goWr), .isRead(isRead),
    .laneCfg(laneCfg), .fastEn(fastEn), .fallStb(fallStb), .strb(strb)
  );

  fbe_dp #(.AddrBytes(AddrBytes), .HalfDiv(HalfDiv)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opcFast(opcFast),
    .opcQuad(opcQuad), .wrByte(wrByte), .addrQ(addrQ), .ioIn(ioIn),
    .sclk(sclk), .csN(csN), .ioOut(ioOut), .ioOe(ioOe),
    .rxByte(rxByte), .fallStb(fallStb)
  );

endmodule

// File: tb/flash_byte_engine_tb.sv
`timescale 1ns/1ps
module flash_byte_engine_tb;

  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       sclk, csN;
  logic [3:0] ioOut, ioOe;
  logic [3:0] flashIo = 4'h0;

  int total = 0;
  int bad = 0;

  always #4 clk = !clk;

  flash_byte_engine #(.AddrBytes(3), .HalfDiv(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclk(sclk), .csN(csN),
    .ioOut(ioOut), .ioOe(ioOe), .ioIn(flashIo)
  );

  // ---------------- flash model ----------------
  logic [7:0]  mem [256];
  int          mAddrW = 1, mDataW = 1, mDummy = 0;
  int          bitCnt = 0, frames = 0, oeViol = 0;
  logic [7:0]  opc = 0, wdat = 0;
  logic [23:0] adr = 0;
  logic [7:0]  lastOpc = 0, lastWdat = 0;
  logic [23:0] lastAddr = 0;
  int          lastClks = 0;
  logic        wel = 0, wrenSeen = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));

  always @(negedge csN) begin
    bitCnt = 0; opc = 0; adr = 0; wdat = 0; flashIo = 4'h0;
  end

  always @(posedge sclk) begin
    if (csN === 1'b0) begin
      if (bitCnt < 8) opc = {opc[6:0], ioOut[0]};
      else if (opc == 8'h02) begin
        if (bitCnt < 32) adr = {adr[22:0], ioOut[0]};
        else wdat = {wdat[6:0], ioOut[0]};
      end else if (opc != 8'h06) begin
        if (bitCnt < 8 + 24 / mAddrW) begin
          case (mAddrW)
            2:       adr = {adr[21:0], ioOut[1], ioOut[0]};
            4:       adr = {adr[19:0], ioOut[3:0]};
            default: adr = {adr[22:0], ioOut[0]};
          endcase
        end else if (ioOe != 4'h0) oeViol++;
      end
      bitCnt++;
    end
  end

  always @(negedge sclk) begin
    #1;
    if (csN === 1'b0 && bitCnt >= 8 && opc != 8'h02 && opc != 8'h06) begin
      int ds, k;
      logic [7:0] b;
      ds = 8 + 24 / mAddrW + mDummy;
      if (bitCnt >= ds && bitCnt < ds + 8 / mDataW) begin
        k = bitCnt - ds;
        b = mem[adr[7:0]];
        case (mDataW)
          2:       flashIo = {2'b00, b[7-2*k], b[6-2*k]};
          4:       flashIo = (k == 0) ? b[7:4] : b[3:0];
          default: flashIo = {2'b00, b[7-k], 1'b0};
        endcase
      end
    end
  end

  always @(posedge csN) begin
    frames++;
    lastOpc = opc; lastAddr = adr; lastClks = bitCnt; lastWdat = wdat;
    if (opc == 8'h06 && bitCnt == 8) begin wel = 1; wrenSeen = 1; end
    if (opc == 8'h02 && bitCnt == 40 && wel) begin mem[adr[7:0]] = wdat; wel = 0; end
  end

  // serial clock high-phase monitor
  int hiRun = 0, hiBad = 0, hiSeen = 0;
  always @(negedge clk) begin
    if (sclk === 1'b1) hiRun++;
    else if (hiRun != 0) begin
      hiSeen++;
      if (hiRun != HALF) hiBad++;
      hiRun = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic waitIdle();
    logic [7:0] v;
    for (int n = 0; n < 3000; n++) begin
      regRead(8'h00, v);
      if (v == 8'h00) break;
    end
  endtask

  task automatic setAddr(input logic [31:0] a);
    for (int i = 0; i < 4; i++) regWrite(8'h40 + 8'(i), a[8*i +: 8]);
  endtask

  task automatic doRead(input string req, input logic [23:0] a, input logic [7:0] expOpc,
                        input int aw, input int dw, input int dm);
    logic [7:0] v;
    int f0, ov0;
    mAddrW = aw; mDataW = dw; mDummy = dm;
    f0 = frames; ov0 = oeViol;
    regWrite(8'h00, 8'h81);
    regRead(8'h00, v);
    check("R2", "cmd busy", 32'(v), 32'h81);
    waitIdle();
    check(req, "frame count", frames - f0, 1);
    check(req, "opcode", 32'(lastOpc), 32'(expOpc));
    check(req, "address", 32'(lastAddr), 32'(a));
    check(req, "clocks", lastClks, 8 + 24 / aw + dm + 8 / dw);
    check("R8", "bus released", oeViol - ov0, 0);
    regRead(8'h0c, v);
    check(req, "read byte", 32'(v), 32'(mem[a[7:0]]));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [7:0] v;
    check("R1", "csN", 32'(csN), 1);
    check("R1", "sclk", 32'(sclk), 0);
    check("R1", "oe", 32'(ioOe), 0);
    regRead(8'h00, v); check("R1", "cmd", 32'(v), 0);
    regRead(8'hcc, v); check("R1", "lane", 32'(v), 0);
    regRead(8'h64, v); check("R1", "rdcfg", 32'(v), 0);
    regRead(8'h2c, v); check("R1", "opc fast", 32'(v), 32'h0B);
    regRead(8'h30, v); check("R1", "opc quad", 32'(v), 32'h6B);
  endtask

  task automatic t_single_seq();
    logic [7:0] v;
    setAddr(32'h0000_0010);
    doRead("R6", 24'h10, 8'h03, 1, 1, 0);
    doRead("R4", 24'h11, 8'h03, 1, 1, 0);
    regRead(8'h40, v); check("R4", "addr after two reads", 32'(v), 32'h12);
  endtask

  task automatic t_fast();
    regWrite(8'h64, 8'h01);
    setAddr(32'h0000_0033);
    doRead("R7", 24'h33, 8'h0B, 1, 1, 8);
  endtask

  task automatic t_dual();
    regWrite(8'h2c, 8'h3B);
    regWrite(8'hcc, 8'h03);
    setAddr(32'h0012_3456);
    doRead("R5", 24'h123456, 8'h3B, 2, 2, 8);
    regWrite(8'hcc, 8'h01);
    setAddr(32'h0000_00A7);
    doRead("R9", 24'h0000A7, 8'h3B, 1, 2, 8);
  endtask

  task automatic t_quad();
    regWrite(8'h30, 8'hEB);
    regWrite(8'hcc, 8'h0C);
    setAddr(32'h00AB_CD5E);
    doRead("R9", 24'hABCD5E, 8'hEB, 4, 4, 8);
    regWrite(8'hcc, 8'h0D);
    setAddr(32'h0000_0071);
    doRead("R5", 24'h000071, 8'hEB, 4, 4, 8);
    regWrite(8'hcc, 8'h04);
    setAddr(32'h0000_0090);
    doRead("R6", 24'h000090, 8'hEB, 1, 4, 8);
  endtask

  task automatic t_write();
    logic [7:0] v;
    int f0;
    regWrite(8'hcc, 8'h0C);
    regWrite(8'h1c, 8'hA5);
    setAddr(32'h0000_00FF);
    wrenSeen = 0; f0 = frames;
    regWrite(8'h00, 8'h90);
    regRead(8'h00, v); check("R3", "cmd busy", 32'(v), 32'h90);
    waitIdle();
    check("R3", "frames", frames - f0, 2);
    check("R3", "wren frame", 32'(wrenSeen), 1);
    check("R3", "prog opcode", 32'(lastOpc), 32'h02);
    check("R3", "prog address", 32'(lastAddr), 32'hFF);
    check("R3", "prog clocks", lastClks, 40);
    check("R3", "flash byte", 32'(mem[8'hFF]), 32'hA5);
    regRead(8'h40, v); check("R4", "addr byte0 after carry", 32'(v), 32'h00);
    regRead(8'h41, v); check("R4", "addr byte1 after carry", 32'(v), 32'h01);
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    int f0;
    f0 = frames;
    regWrite(8'h00, 8'h55);
    regRead(8'h00, v); check("R10", "bad cmd stays idle", 32'(v), 0);
    repeat (20) @(negedge clk);
    check("R10", "no frame for bad cmd", frames - f0, 0);
    regWrite(8'hcc, 8'h00);
    regWrite(8'h1c, 8'h3C);
    setAddr(32'h0000_0020);
    regWrite(8'h00, 8'h90);
    regWrite(8'h1c, 8'h00);
    regWrite(8'hcc, 8'h0F);
    regWrite(8'h40, 8'h77);
    waitIdle();
    check("R10", "busy wdata write ignored", 32'(mem[8'h20]), 32'h3C);
    regRead(8'hcc, v); check("R10", "busy lane write ignored", 32'(v), 0);
    regRead(8'h40, v); check("R10", "busy addr write ignored", 32'(v), 32'h21);
  endtask

  task automatic t_clock();
    check("R11", "high phase length errors", hiBad, 0);
    check("R11", "high phases seen", 32'(hiSeen > 0), 1);
    check("R11", "idle clock low", 32'(sclk), 0);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_single_seq();
    t_fast();
    t_dual();
    t_quad();
    t_write();
    t_ignore();
    t_clock();
    finishRun();
  end

endmodule